// File: doc/BRIEF.md
# Block-Banked Memory Address Generator

This block produces the 12-bit memory address of a small accumulator processor whose 4 KB memory is split into sixteen 256-byte blocks. It keeps three pieces of state: a 4-bit current-block register that names the block where code runs, an 8-bit program counter that counts inside that block, and an 8-bit far-block field whose upper nibble picks the block for absolute data accesses.

During the fetch phase the address is the current block joined with the program counter. During the execute phase the address depends on the addressing mode. In relative mode the operand is an offset from the base of the current block. In absolute mode the operand is an offset into the block held in the far field. Immediate and inherent modes do not touch memory. Branches load the counter from the operand. A separate switch-block control loads the block register from the low nibble of the operand.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset the program counter, the block register and the far field are all zero, so the first fetch address is 0x000.
- R2: While `fetch_ph` is high the address is {block, pc} and `mem_en` is 1, whatever `exec_ph` and `mode` are.
- R3: `pc_inc` adds one to the program counter. The counter wraps from 0xFF to 0x00 and never changes the block register.
- R4: `pc_load` loads the program counter from `operand`, takes priority over `pc_inc` and leaves the block register unchanged.
- R5: `blk_sel` loads the block register from `operand[3:0]`. `operand[7:4]` has no effect on it.
- R6: With `exec_ph` high, `fetch_ph` low and `mode` = 2'b01 (relative), the address is {block, operand} and `mem_en` is 1.
- R7: `far_load` loads the far field from `operand`. With `exec_ph` high, `fetch_ph` low and `mode` = 2'b10 (absolute), the address is {far[7:4], operand} and `mem_en` is 1.
- R8: With `exec_ph` high, `fetch_ph` low and `mode` = 2'b00 (immediate) or 2'b11 (inherent), `mem_en` is 0 and the address is 0x000.
- R9: With both phase strobes low, `mem_en` is 0 and the address is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand | input | 8 | Operand byte of the current instruction |
| mode | input | 2 | Addressing mode: 00 immediate, 01 relative, 10 absolute, 11 inherent |
| fetch_ph | input | 1 | Fetch phase strobe |
| exec_ph | input | 1 | Execute phase strobe |
| pc_inc | input | 1 | Increment the program counter |
| pc_load | input | 1 | Load the program counter from the operand (branch) |
| blk_sel | input | 1 | Load the block register from the operand's low nibble |
| far_load | input | 1 | Load the far-block field from the operand |
| addr | output | 12 | Memory address |
| mem_en | output | 1 | Memory is accessed this cycle |

## Verification
The fetch address is tested by walking the counter across the 0xFF boundary after the block has been moved off zero. A carry into the block number would show up in that test. Relative and absolute accesses use the same operand once the block register and the far nibble hold different values, so the two sources of the upper address bits can be told apart. Branches are issued together with increments and with block switches, which exposes the load priority and any disturbance of the block register. Operands with a non-zero upper nibble on a block switch show whether those bits leak into the block register. The non-accessing modes and idle cycles are then given operands that a memory-accessing mode would have turned into addresses.

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int BLK_W = 4,
  parameter int OFS_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OFS_W-1:0]       operand,
  input  logic [1:0]             mode,
  input  logic                   fetch_ph,
  input  logic                   exec_ph,
  input  logic                   pc_inc,
  input  logic                   pc_load,
  input  logic                   blk_sel,
  input  logic                   far_load,
  output logic [BLK_W+OFS_W-1:0] addr,
  output logic                   mem_en
);
  localparam int ADDR_W = BLK_W + OFS_W;
  localparam logic [1:0] M_IMM = 2'b00;
  localparam logic [1:0] M_REL = 2'b01;
  localparam logic [1:0] M_ABS = 2'b10;

  logic [OFS_W-1:0] pc_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFS_W-1:0] far_q;
  logic [BLK_W-1:0] far_blk;

  assign far_blk = far_q[OFS_W-1 -: BLK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_load) begin
      pc_q <= operand;
    end else if (pc_inc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_sel) begin
      blk_q <= operand[BLK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_q <= '0;
    end else if (far_load) begin
      far_q <= operand;
    end
  end

  always_comb begin
    addr   = '0;
    mem_en = 1'b0;
    if (fetch_ph) begin
      addr   = {blk_q, pc_q};
      mem_en = 1'b1;
    end else if (exec_ph) begin
      unique case (mode)
        M_REL: begin
          addr   = {blk_q, operand};
          mem_en = 1'b1;
        end
        M_ABS: begin
          addr   = {far_blk, operand};
          mem_en = 1'b1;
        end
        default: begin
          addr   = {ADDR_W{1'b0}};
          mem_en = 1'b0;
        end
      endcase
    end
  end

  logic unused_imm;
  assign unused_imm = (M_IMM == 2'b00);
endmodule

module bank_addr_gen_chk #(
  parameter int BLK_W = 4,
  parameter int OFS_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [OFS_W-1:0]       operand,
  input logic [1:0]             mode,
  input logic                   fetch_ph,
  input logic                   exec_ph,
  input logic                   pc_inc,
  input logic                   pc_load,
  input logic                   blk_sel,
  input logic [OFS_W-1:0]       pc_q,
  input logic [BLK_W-1:0]       blk_q,
  input logic [BLK_W+OFS_W-1:0] addr,
  input logic                   mem_en
);
  AST_FETCH_BLOCK_PC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ph |-> (mem_en && addr == {blk_q, pc_q})); // R2
  AST_PC_WRAP_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_load && !blk_sel && pc_q == '1) |=> (pc_q == '0 && $stable(blk_q))); // R3
  AST_BRANCH_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !blk_sel) |=> (pc_q == $past(operand) && $stable(blk_q))); // R4
  AST_BLOCK_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    blk_sel |=> (blk_q == $past(operand[BLK_W-1:0]))); // R5
  AST_NO_ACCESS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_ph && exec_ph && (mode == 2'b00 || mode == 2'b11)) |-> (!mem_en && addr == '0)); // R8
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_ph && !exec_ph) |-> !mem_en); // R9
endmodule

bind bank_addr_gen bank_addr_gen_chk #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .operand(operand), .mode(mode),
  .fetch_ph(fetch_ph), .exec_ph(exec_ph), .pc_inc(pc_inc), .pc_load(pc_load),
  .blk_sel(blk_sel), .pc_q(pc_q), .blk_q(blk_q), .addr(addr), .mem_en(mem_en)
);

// File: tb/tb_bank_addr_gen.sv
module tb_bank_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  operand = '0;
  logic [1:0]  mode = '0;
  logic        fetch_ph = 0, exec_ph = 0, pc_inc = 0, pc_load = 0, blk_sel = 0, far_load = 0;
  logic [11:0] addr;
  logic        mem_en;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_pc = 0, m_blk = 0, m_far = 0;

  always #5 clk = ~clk;

  bank_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .mode(mode),
    .fetch_ph(fetch_ph), .exec_ph(exec_ph), .pc_inc(pc_inc), .pc_load(pc_load),
    .blk_sel(blk_sel), .far_load(far_load), .addr(addr), .mem_en(mem_en)
  );

  task automatic step(input bit f, input bit e, input bit inc, input bit ld,
                      input bit bs, input bit fl, input logic [1:0] md,
                      input logic [7:0] op, input string tag);
    int exp_a;
    bit exp_e;
    fetch_ph = f; exec_ph = e; pc_inc = inc; pc_load = ld;
    blk_sel = bs; far_load = fl; mode = md; operand = op;
    #1;
    exp_a = 0; exp_e = 0;
    if (f) begin
      exp_a = m_blk * 256 + m_pc; exp_e = 1;
    end else if (e && md == 2'b01) begin
      exp_a = m_blk * 256 + op; exp_e = 1;
    end else if (e && md == 2'b10) begin
      exp_a = (m_far / 16) * 256 + op; exp_e = 1;
    end
    total++;
    if (addr !== 12'(exp_a) || mem_en !== exp_e) begin
      bad++;
      $display("FAIL %s: addr=%03h mem_en=%0b expected addr=%03h mem_en=%0b",
               tag, addr, mem_en, 12'(exp_a), exp_e);
    end
    @(posedge clk);
    if (ld) m_pc = op;
    else if (inc) m_pc = (m_pc + 1) % 256;
    if (bs) m_blk = op % 16;
    if (fl) m_far = op;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1,0,0,0,0,0,2'b00,8'h00,"R1 reset fetch address");
    step(0,0,0,0,0,0,2'b01,8'h55,"R9 idle no access");
    step(1,1,1,0,0,0,2'b10,8'h33,"R2 fetch beats exec");
    step(0,0,0,0,1,0,2'b00,8'hA7,"R5 switch block upper nibble ignored");
    step(1,0,0,0,0,0,2'b00,8'h00,"R5 block now 7");
    step(0,0,0,1,0,0,2'b00,8'hFD,"R4 branch load");
    for (int i = 0; i < 5; i++) begin
      step(1,0,1,0,0,0,2'b00,8'h00,"R3 increment and wrap in block");
    end
    step(0,1,1,1,0,0,2'b01,8'h40,"R4 load beats increment, R6 relative");
    step(1,0,0,0,0,0,2'b00,8'h00,"R4 pc from branch, block kept");
    step(0,0,0,0,0,1,2'b00,8'hC2,"R7 far load");
    step(0,1,0,0,0,0,2'b10,8'h19,"R7 absolute uses far nibble");
    step(0,1,0,0,0,0,2'b01,8'h19,"R6 relative uses block");
    step(0,1,0,0,0,0,2'b00,8'hEE,"R8 immediate no access");
    step(0,1,0,0,0,0,2'b11,8'hEE,"R8 inherent no access");
    step(0,1,0,1,1,0,2'b01,8'h3C,"R4 R5 far jump");
    step(1,0,0,0,0,0,2'b00,8'h00,"R4 R5 after far jump");
    step(0,0,0,0,1,0,2'b00,8'hF0,"R5 block back to 0");
    for (int i = 0; i < 300; i++) begin
      step(1,0,1,0,0,0,2'b00,8'h00,"R3 full lap in block 0");
    end
    step(0,1,0,0,0,0,2'b10,8'hFF,"R7 absolute top offset");
    step(0,0,0,0,0,0,2'b10,8'hFF,"R9 idle with absolute mode");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule